// File: doc/BRIEF.md
# Two-Tap Adaptive Mismatch Estimator

This block sits behind the tone-extraction stage of a two-way time-interleaved converter. It receives, for each sample pair, the recovered calibration-tone value from the even sub-converter (`x0_in`) and from the odd one (`x1_in`). In the background, it adapts a two-coefficient predictor that models the odd-channel tone as a weighted sum of the present even-channel value and the even-channel value from the previous valid sample. The adaptation uses a least-mean-squares rule whose step size is a power of two chosen through `mu_shift`.

The two coefficients are exported unchanged. They are also mapped to first-order estimates of the inter-channel gain mismatch and sampling-instant mismatch for the downstream correction logic. Each estimate is a weighted sum of the deviation of the first coefficient from its nominal value and of the second coefficient. The four weights are inputs, because they depend on where the calibration tone is placed. The update rate can be lowered by an integer factor.

A `converged` flag indicates a long run of small prediction errors. Coefficients are fixed point with 16 fraction bits, so the nominal first coefficient of 1.0 is 65536.

Top module: `two_tap_mismatch_est`

## Requirements
- R1: While reset is asserted, and once it has been released with no valid sample since, `h0` = 65536, `h1` = 0, `gain_err` = 0, `timing_err` = 0 and `converged` = 0.
- R2: For each valid sample the prediction error is e = x1 − ((h0·x0 + h1·xp) >>> 16). Here xp is the `x0_in` of the previous valid sample, or 0 if there has been none since reset.
- R3: On an updating sample, h0 becomes h0 + ((e·x0) >>> mu_shift) and h1 becomes h1 + ((e·xp) >>> mu_shift). The new values appear on the ports one clock later.
- R4: Each coefficient saturates to the 18-bit signed range, −131072 to 131071, and never wraps.
- R5: The effective decimation is D = `decim`. A value of 0 is treated as 1, and values above 16 are treated as 16. Valid samples are numbered from 0 after reset, and only samples whose number is a multiple of D update the coefficients. Every valid sample still advances xp.
- R6: While `in_valid` is low, the coefficients, xp and the convergence state do not change.
- R7: `gain_err` = sat18((kg_a·(h0 − 65536) + kg_b·h1) >>> 16) and `timing_err` = sat18((kt_a·(h0 − 65536) + kt_b·h1) >>> 16). Both are taken from the coefficient values of the previous clock.
- R8: `converged` goes high in the cycle after the 1024th consecutive updating sample with |e| < `err_thresh`. Samples skipped by decimation neither count nor break the run.
- R9: An updating sample with |e| ≥ `err_thresh` clears `converged` and restarts the run. This happens in the same cycle as that sample's coefficient update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Marks a valid tone sample pair |
| x0_in | input | 12 | Even-channel tone sample, signed |
| x1_in | input | 12 | Odd-channel tone sample, signed |
| mu_shift | input | 6 | Step size as a right-shift amount |
| decim | input | 5 | Update decimation factor (0 acts as 1, clamped to 16) |
| err_thresh | input | 16 | Unsigned error magnitude bound for convergence |
| kg_a | input | 18 | Gain weight on h0 deviation, signed Q16 |
| kg_b | input | 18 | Gain weight on h1, signed Q16 |
| kt_a | input | 18 | Timing weight on h0 deviation, signed Q16 |
| kt_b | input | 18 | Timing weight on h1, signed Q16 |
| h0 | output | 18 | Present-sample coefficient, signed Q16 |
| h1 | output | 18 | Previous-sample coefficient, signed Q16 |
| gain_err | output | 18 | Gain mismatch estimate, signed |
| timing_err | output | 18 | Timing mismatch estimate, signed |
| converged | output | 1 | Long run of small errors seen |

## Verification
The coefficient update and the clearing of the convergence run are both decided by the same updating sample. One case is provoked on purpose: the run is first brought to exactly 1024 with error-free pairs (odd sample equal to even sample at nominal coefficients), and then a pair with an error of 10 is sent. This case is judged by checking, on the following clock, that the coefficients have moved by the model's expected amounts and that the flag has dropped. The table walk and the decimation sweep then mix updating and skipped samples, so that the flag logic and the coefficient logic must stay in agreement on which samples count.

// File: rtl/mme_pkg.sv
package mme_pkg;
  // Default geometry shared by the estimator and its sub-blocks.
  localparam int DEF_DW   = 12;   // tone sample width
  localparam int DEF_CW   = 18;   // coefficient width
  localparam int DEF_CF   = 16;   // coefficient fraction bits
  localparam int DEF_SHW  = 6;    // step-shift width
  localparam int DEF_TW   = 16;   // threshold width
  localparam int DEF_MAXD = 16;   // largest decimation factor
  localparam int DEF_CONV = 1024; // run length for the converged flag
endpackage

// File: rtl/mme_pacer.sv
module mme_pacer
  import mme_pkg::*;
#(
  parameter int MAXD = DEF_MAXD,
  localparam int DECW = $clog2(MAXD + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [DECW-1:0] decim,
  output logic            upd
);
  logic [DECW-1:0] dsel;
  logic [DECW-1:0] phase_q, phase_d, phase_inc;

  // clamp the requested factor into 1..MAXD
  always_comb begin
    if (decim == '0)
      dsel = DECW'(1);
    else if (decim > DECW'(MAXD))
      dsel = DECW'(MAXD);
    else
      dsel = decim;
  end

  assign phase_inc = phase_q + DECW'(1);
  assign upd       = in_valid && (phase_q == '0);

  always_comb begin
    phase_d = phase_q;
    if (phase_inc >= dsel)
      phase_d = '0;
    else
      phase_d = phase_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase_q <= '0;
    else if (in_valid)
      phase_q <= phase_d;
  end
endmodule

// File: rtl/mme_tap_core.sv
module mme_tap_core
  import mme_pkg::*;
#(
  parameter int DW     = DEF_DW,
  parameter int CW     = DEF_CW,
  parameter int CF     = DEF_CF,
  parameter int SHW    = DEF_SHW,
  parameter int H0_NOM = 1 << DEF_CF,
  localparam int PW = CW + DW,
  localparam int SW = PW + 1,
  localparam int EW = SW + 1,
  localparam int UW = EW + DW,
  localparam int NW = UW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 upd,
  input  logic signed [DW-1:0] x0_in,
  input  logic signed [DW-1:0] x1_in,
  input  logic        [SHW-1:0] mu_shift,
  output logic signed [CW-1:0] h0_o,
  output logic signed [CW-1:0] h1_o,
  output logic signed [EW-1:0] err_o
);
  localparam logic signed [NW-1:0] TMAX = NW'((64'sd1 <<< (CW - 1)) - 64'sd1);
  localparam logic signed [NW-1:0] TMIN = -TMAX - NW'(1);

  logic signed [CW-1:0] h0_q, h0_d, h1_q, h1_d;
  logic signed [DW-1:0] xp_q, xp_d;
  logic signed [PW-1:0] p0, p1;
  logic signed [SW-1:0] acc, pred;
  logic signed [UW-1:0] g0, g1, d0, d1;
  logic signed [NW-1:0] s0, s1;

  function automatic logic signed [CW-1:0] sat_tap(input logic signed [NW-1:0] v);
    if (v > TMAX)
      return TMAX[CW-1:0];
    else if (v < TMIN)
      return TMIN[CW-1:0];
    else
      return v[CW-1:0];
  endfunction

  // predictor output and residual
  assign p0    = PW'(h0_q) * PW'(x0_in);
  assign p1    = PW'(h1_q) * PW'(xp_q);
  assign acc   = SW'(p0) + SW'(p1);
  assign pred  = acc >>> CF;
  assign err_o = EW'(x1_in) - EW'(pred);

  // gradient steps scaled by the power-of-two step size
  assign g0 = UW'(err_o) * UW'(x0_in);
  assign g1 = UW'(err_o) * UW'(xp_q);
  assign d0 = g0 >>> mu_shift;
  assign d1 = g1 >>> mu_shift;
  assign s0 = NW'(h0_q) + NW'(d0);
  assign s1 = NW'(h1_q) + NW'(d1);

  always_comb begin
    h0_d = h0_q;
    h1_d = h1_q;
    xp_d = x0_in;
    if (upd) begin
      h0_d = sat_tap(s0);
      h1_d = sat_tap(s1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h0_q <= CW'(H0_NOM);
      h1_q <= '0;
      xp_q <= '0;
    end else if (in_valid) begin
      h0_q <= h0_d;
      h1_q <= h1_d;
      xp_q <= xp_d;
    end
  end

  assign h0_o = h0_q;
  assign h1_o = h1_q;
endmodule

// File: rtl/mme_conv_mon.sv
module mme_conv_mon
  import mme_pkg::*;
#(
  parameter int EW  = 32,
  parameter int TW  = DEF_TW,
  parameter int LEN = DEF_CONV,
  localparam int CNTW = $clog2(LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd,
  input  logic signed [EW-1:0] err,
  input  logic        [TW-1:0] thresh,
  output logic                 converged
);
  logic [EW-1:0]   mag;
  logic            below;
  logic [CNTW-1:0] cnt_q, cnt_d;

  assign mag   = err[EW-1] ? $unsigned(-err) : $unsigned(err);
  assign below = mag < EW'(thresh);

  always_comb begin
    cnt_d = cnt_q;
    if (!below)
      cnt_d = '0;
    else if (cnt_q != CNTW'(LEN))
      cnt_d = cnt_q + CNTW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (upd)
      cnt_q <= cnt_d;
  end

  assign converged = (cnt_q == CNTW'(LEN));
endmodule

// File: rtl/mme_lincomb.sv
module mme_lincomb
  import mme_pkg::*;
#(
  parameter int CW     = DEF_CW,
  parameter int CF     = DEF_CF,
  parameter int H0_NOM = 1 << DEF_CF,
  localparam int DWD = CW + 1,
  localparam int MW  = CW + DWD,
  localparam int AW  = MW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [CW-1:0] h0_i,
  input  logic signed [CW-1:0] h1_i,
  input  logic signed [CW-1:0] k_a,
  input  logic signed [CW-1:0] k_b,
  output logic signed [CW-1:0] y_o
);
  localparam logic signed [AW-1:0] YMAX = AW'((64'sd1 <<< (CW - 1)) - 64'sd1);
  localparam logic signed [AW-1:0] YMIN = -YMAX - AW'(1);

  logic signed [DWD-1:0] dh0;
  logic signed [MW-1:0]  pa, pb;
  logic signed [AW-1:0]  sum, scl;
  logic signed [CW-1:0]  y_d, y_q;

  assign dh0 = DWD'(h0_i) - DWD'(H0_NOM);
  assign pa  = MW'(k_a) * MW'(dh0);
  assign pb  = MW'(k_b) * MW'(h1_i);
  assign sum = AW'(pa) + AW'(pb);
  assign scl = sum >>> CF;

  always_comb begin
    if (scl > YMAX)
      y_d = YMAX[CW-1:0];
    else if (scl < YMIN)
      y_d = YMIN[CW-1:0];
    else
      y_d = scl[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      y_q <= '0;
    else
      y_q <= y_d;
  end

  assign y_o = y_q;
endmodule

// File: rtl/two_tap_mismatch_est.sv
module two_tap_mismatch_est
  import mme_pkg::*;
#(
  parameter int DW       = DEF_DW,
  parameter int CW       = DEF_CW,
  parameter int CF       = DEF_CF,
  parameter int SHW      = DEF_SHW,
  parameter int TW       = DEF_TW,
  parameter int MAXD     = DEF_MAXD,
  parameter int CONV_LEN = DEF_CONV,
  parameter int H0_NOM   = 1 << DEF_CF,
  localparam int DECW = $clog2(MAXD + 1),
  localparam int EW   = CW + DW + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic signed [DW-1:0]  x0_in,
  input  logic signed [DW-1:0]  x1_in,
  input  logic        [SHW-1:0] mu_shift,
  input  logic        [DECW-1:0] decim,
  input  logic        [TW-1:0]  err_thresh,
  input  logic signed [CW-1:0]  kg_a,
  input  logic signed [CW-1:0]  kg_b,
  input  logic signed [CW-1:0]  kt_a,
  input  logic signed [CW-1:0]  kt_b,
  output logic signed [CW-1:0]  h0,
  output logic signed [CW-1:0]  h1,
  output logic signed [CW-1:0]  gain_err,
  output logic signed [CW-1:0]  timing_err,
  output logic                  converged
);
  logic [1:0]           rst_sync_q;
  logic                 rst_s_n;
  logic                 upd_w;
  logic signed [EW-1:0] err_w;
  logic signed [CW-1:0] h0_w, h1_w;
  logic signed [CW-1:0] ka [2];
  logic signed [CW-1:0] kb [2];
  logic signed [CW-1:0] ymap [2];

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  mme_pacer #(.MAXD(MAXD)) u_pacer (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .in_valid (in_valid),
    .decim    (decim),
    .upd      (upd_w)
  );

  mme_tap_core #(
    .DW(DW), .CW(CW), .CF(CF), .SHW(SHW), .H0_NOM(H0_NOM)
  ) u_taps (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .in_valid (in_valid),
    .upd      (upd_w),
    .x0_in    (x0_in),
    .x1_in    (x1_in),
    .mu_shift (mu_shift),
    .h0_o     (h0_w),
    .h1_o     (h1_w),
    .err_o    (err_w)
  );

  mme_conv_mon #(.EW(EW), .TW(TW), .LEN(CONV_LEN)) u_conv (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .upd       (upd_w),
    .err       (err_w),
    .thresh    (err_thresh),
    .converged (converged)
  );

  assign ka[0] = kg_a;
  assign kb[0] = kg_b;
  assign ka[1] = kt_a;
  assign kb[1] = kt_b;

  // one mapping lane per mismatch estimate
  for (genvar gi = 0; gi < 2; gi++) begin : g_map
    mme_lincomb #(.CW(CW), .CF(CF), .H0_NOM(H0_NOM)) u_map (
      .clk   (clk),
      .rst_n (rst_s_n),
      .h0_i  (h0_w),
      .h1_i  (h1_w),
      .k_a   (ka[gi]),
      .k_b   (kb[gi]),
      .y_o   (ymap[gi])
    );
  end

  assign h0         = h0_w;
  assign h1         = h1_w;
  assign gain_err   = ymap[0];
  assign timing_err = ymap[1];
endmodule

// File: rtl/mme_checker.sv
module mme_checker #(
  parameter int CW = 18,
  parameter int EW = 32,
  parameter int TW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 upd,
  input logic signed [EW-1:0] err,
  input logic        [TW-1:0] thr,
  input logic signed [CW-1:0] h0,
  input logic signed [CW-1:0] h1,
  input logic signed [CW-1:0] kg_a,
  input logic signed [CW-1:0] kg_b,
  input logic signed [CW-1:0] kt_a,
  input logic signed [CW-1:0] kt_b,
  input logic signed [CW-1:0] gain,
  input logic signed [CW-1:0] timing,
  input logic                 converged
);
  logic [EW-1:0] mag;
  logic          big;
  assign mag = err[EW-1] ? $unsigned(-err) : $unsigned(err);
  assign big = mag >= EW'(thr);

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(h0) && $stable(h1)));

  assert_skip_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !upd) |=> ($stable(h0) && $stable(h1)));

  assert_big_err_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && big) |=> !converged);

  assert_rise_needs_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(converged) |-> $past(upd));

  assert_map_follows_taps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(h0) && $stable(h1) && $stable(kg_a) && $stable(kg_b) &&
     $stable(kt_a) && $stable(kt_b)) |=> ($stable(gain) && $stable(timing)));
endmodule

bind two_tap_mismatch_est mme_checker #(.CW(CW), .EW(EW), .TW(TW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_s_n),
  .in_valid  (in_valid),
  .upd       (upd_w),
  .err       (err_w),
  .thr       (err_thresh),
  .h0        (h0),
  .h1        (h1),
  .kg_a      (kg_a),
  .kg_b      (kg_b),
  .kt_a      (kt_a),
  .kt_b      (kt_b),
  .gain      (gain_err),
  .timing    (timing_err),
  .converged (converged)
);

// File: tb/two_tap_mismatch_est_tb_top.sv
module two_tap_mismatch_est_tb_top;
  logic               clk;
  logic               rst_n;
  logic               in_valid;
  logic signed [11:0] x0_in, x1_in;
  logic [5:0]         mu_shift;
  logic [4:0]         decim;
  logic [15:0]        err_thresh;
  logic signed [17:0] kg_a, kg_b, kt_a, kt_b;
  logic signed [17:0] h0, h1, gain_err, timing_err;
  logic               converged;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference state
  longint m_h0, m_h1, m_xp;
  int     m_phase, m_cnt;

  // stimulus table: x0, x1, step shift
  localparam int NV = 8;
  localparam int TV [NV][3] = '{
    '{  500,   520, 12}, '{ -700,  -650, 12}, '{ 1024,   900, 10},
    '{-1500, -1480, 14}, '{ 2047,  2000, 11}, '{-2048, -2000, 13},
    '{    0,    37,  9}, '{  813,  -812, 15}
  };

  two_tap_mismatch_est dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x0_in(x0_in), .x1_in(x1_in),
    .mu_shift(mu_shift), .decim(decim), .err_thresh(err_thresh),
    .kg_a(kg_a), .kg_b(kg_b), .kt_a(kt_a), .kt_b(kt_b),
    .h0(h0), .h1(h1), .gain_err(gain_err), .timing_err(timing_err),
    .converged(converged)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic longint sat18(input longint v);
    if (v > 131071) return 131071;
    if (v < -131072) return -131072;
    return v;
  endfunction

  function automatic longint map_ref(input longint a, input longint b);
    return sat18((a * (m_h0 - 65536) + b * m_h1) >>> 16);
  endfunction

  task automatic mdl_reset();
    m_h0 = 65536; m_h1 = 0; m_xp = 0; m_phase = 0; m_cnt = 0;
  endtask

  task automatic mdl_step(input longint x0v, input longint x1v);
    int d;
    longint e, mag;
    d = int'(decim);
    if (d == 0) d = 1;
    if (d > 16) d = 16;
    e = x1v - ((m_h0 * x0v + m_h1 * m_xp) >>> 16);
    if (m_phase == 0) begin
      m_h0 = sat18(m_h0 + ((e * x0v) >>> mu_shift));
      m_h1 = sat18(m_h1 + ((e * m_xp) >>> mu_shift));
      mag = (e < 0) ? -e : e;
      if (mag >= longint'(err_thresh)) m_cnt = 0;
      else if (m_cnt < 1024) m_cnt++;
    end
    m_xp = x0v;
    m_phase = (m_phase + 1 >= d) ? 0 : m_phase + 1;
  endtask

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    chk(req, "h0", h0, m_h0);
    chk(req, "h1", h1, m_h1);
    chk("R8", "converged", longint'(converged), (m_cnt == 1024) ? 1 : 0);
    chk("R7", "gain_err", gain_err, map_ref(kg_a, kg_b));
    chk("R7", "timing_err", timing_err, map_ref(kt_a, kt_b));
  endtask

  task automatic apply(input int x0v, input int x1v);
    @(negedge clk);
    x0_in = 12'(x0v); x1_in = 12'(x1v); in_valid = 1'b1;
    mdl_step(x0v, x1v);
    @(negedge clk);
    in_valid = 1'b0; x0_in = '0; x1_in = '0;
    @(negedge clk);
  endtask

  task automatic check_reset_vals();
    chk("R1", "h0", h0, 65536);
    chk("R1", "h1", h1, 0);
    chk("R1", "gain_err", gain_err, 0);
    chk("R1", "timing_err", timing_err, 0);
    chk("R1", "converged", longint'(converged), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_reset_vals();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mdl_reset();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected run completion");
    finish_run();
  end

  initial begin
    longint sh0, sh1;
    rst_n = 1'b0; in_valid = 1'b0; x0_in = '0; x1_in = '0;
    mu_shift = 6'd8; decim = 5'd1; err_thresh = 16'd1;
    kg_a = 18'sd32768; kg_b = -18'sd8192; kt_a = 18'sd4096; kt_b = 18'sd49152;
    mdl_reset();
    repeat (3) @(negedge clk);
    check_reset_vals();              // R1 during reset
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_reset_vals();              // R1 after release

    // R8: exact-prediction run; nominal taps give e = 0
    for (int i = 0; i < 1023; i++) begin
      int v;
      v = ((i * 37) % 2000) - 1000;
      apply(v, v);
    end
    chk("R8", "converged after 1023", longint'(converged), 0);
    apply(321, 321);
    chk("R8", "converged after 1024", longint'(converged), 1);
    chk("R3", "h0 unmoved by zero error", h0, 65536);

    // R9: large error on the sample that also moves the taps
    apply(100, 110);
    chk("R9", "converged cleared", longint'(converged), 0);
    check_state("R9");

    // R6: idle cycles with wiggling data
    sh0 = h0; sh1 = h1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      x0_in = 12'(i * 311); x1_in = 12'(-i * 97);
    end
    @(negedge clk);
    chk("R6", "h0 held", h0, sh0);
    chk("R6", "h1 held", h1, sh1);
    apply(-400, -390);               // xp must still be 110's partner 100
    check_state("R6");

    // R2/R3: table walk
    for (int k = 0; k < NV; k++) begin
      mu_shift = 6'(TV[k][2]);
      apply(TV[k][0], TV[k][1]);
      check_state("R2");
      check_state("R3");
    end

    // R5: decimation by 4, by 0 (acts as 1), by 20 (acts as 16)
    mu_shift = 6'd10;
    decim = 5'd4;
    for (int i = 0; i < 8; i++) begin
      apply(300 + i * 50, 280 - i * 40);
      check_state("R5");
    end
    decim = 5'd0;
    for (int i = 0; i < 4; i++) begin
      apply(-200 - i * 30, -180);
      check_state("R5");
    end
    decim = 5'd20;
    for (int i = 0; i < 17; i++) begin
      apply(700 - i * 60, 650);
      check_state("R5");
    end

    // R4: saturation at both ends
    decim = 5'd1;
    do_reset();
    mu_shift = 6'd0;
    apply(2047, -2048);
    chk("R4", "h0 low limit", h0, -131072);
    check_state("R4");
    apply(-2048, 2047);
    chk("R4", "h0 high limit", h0, 131071);
    chk("R4", "h1 low limit", h1, -131072);
    check_state("R4");

    do_reset();                      // R1 again after activity
    check_reset_vals();
    finish_run();
  end
endmodule